// File: doc/BRIEF.md
# Firmware Block Download Controller

This block is a bus master that boots a remote processor by pushing a firmware image into the circular SRAM window of the remote side's bootloader. On a start pulse it prepares the remote control area and parks the remote CPU on a branch-to-self instruction. It then takes the CPU out of reset and turns its clock on. Once the bootloader answers a probe, the block announces the image length and streams the image in fixed-size blocks taken from a byte stream. Flow control keeps the remote buffer from overrunning. At the end it reports either completion or one of four error codes.

All remote access goes through a single 32-bit request/acknowledge register port with one transaction in flight. Waits between failed polls are counted in milliseconds, derived from a cycle prescaler parameter. Block size, buffer size, register addresses, handshake codes and the two config bit positions are all parameters.

Top module: `fw_push_engine`

## Requirements
- R1: After start, the first five transactions are writes, in this order: the probe code to the size register, 0 to the put register, 0 to the get register, the pending code to the status register, and 0 to the flags register.
- R2: Next come two writes: 0xFFF20000 to the SRAM base register, then 0xEAFFFFFE to the data port register.
- R3: The block reads the config register. It writes that value back with bit RST_BIT cleared. It then writes it again with both RST_BIT and CLKOFF_BIT cleared.
- R4: The block reads the size register until it returns the reply code. The wait index i starts at 0. After a miss the block waits at least i*CYC_PER_MS cycles, then sets i to i+1+i/2, and reads again while i<100. If the reply never comes, it ends with error code 1.
- R5: After the reply, the block writes the image length to the size register. It then sends ceil(len/BLK_BYTES) blocks. A zero length sends no block.
- R6: Before each block the status register is read. Any value other than the pending code ends the run with error code 2.
- R7: Before each block the get register is read, up to 100 times, until put−get ≤ FIFO_BYTES−BLK_BYTES. The wait after try t (counted from 0) is at least t*CYC_PER_MS cycles. If the condition is never met, the run ends with error code 3.
- R8: A block is written as BLK_BYTES/4 word writes. Word w goes to FIFO_BASE + (put & (FIFO_BYTES−1)) + 4w. Inside each word, the lowest byte is the earliest stream byte.
- R9: Bytes past the image end are sent as zeros. After each block, put advances by the real byte count only, and the new put value is written to the put register.
- R10: After the last block, the status register is polled with the R4 backoff while i<300. The run is done if the first non-pending value equals the success code. Any other value, or a pending value once the limit is reached, gives error code 4.
- R11: in_ready is high only while a word is being filled and image bytes remain. Exactly len bytes are taken from the stream.
- R12: bus_req stays high with stable we, addr and wdata until bus_ack. It is low in the cycle after the acknowledge.
- R13: Reset clears done, err, err_code (code 0 means none), bus_req and in_ready. done and err are never both high. They hold until the next start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start | input | 1 | start pulse, taken when idle |
| img_len | input | 32 | image length in bytes, sampled with start |
| in_data | input | 8 | image byte |
| in_valid | input | 1 | image byte valid |
| in_ready | output | 1 | image byte accepted |
| bus_req | output | 1 | register transaction request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | register address |
| bus_wdata | output | 32 | write data |
| bus_ack | input | 1 | transaction acknowledge |
| bus_rdata | input | 32 | read data, valid with bus_ack |
| done | output | 1 | download completed |
| err | output | 1 | download failed |
| err_code | output | 3 | 1 ready timeout, 2 bad status, 3 buffer timeout, 4 completion failure |

## Verification
The main function is tried with several image lengths. A length that is not a multiple of the block size exercises padding and the short put step. An exact multiple whose put wraps past the buffer size shows the address masking. Zero length shows that no block is sent. Remote responses vary so each path is separated from the others: a get pointer that keeps pace, one that lags once and then catches up, and one that never moves. The probe is answered late or never. The status register reports a fault mid-stream. The final status is success after a few pending reads, a wrong code, or pending until the poll limit. Every bus transaction is compared in order against the expected sequence, including the minimum idle gap before each retry.

// File: rtl/fw_push_engine.sv
module fw_push_engine #(
  parameter int          BLK_BYTES   = 1024,
  parameter int          FIFO_BYTES  = 32768,
  parameter int          CYC_PER_MS  = 100000,
  parameter logic [31:0] A_SIZE      = 32'h0000_0000,
  parameter logic [31:0] A_PUT       = 32'h0000_0004,
  parameter logic [31:0] A_GET       = 32'h0000_0008,
  parameter logic [31:0] A_STAT      = 32'h0000_000C,
  parameter logic [31:0] A_FLAGS     = 32'h0000_0010,
  parameter logic [31:0] A_SRAM_BASE = 32'h0000_0100,
  parameter logic [31:0] A_DPORT     = 32'h0000_0104,
  parameter logic [31:0] A_CFG       = 32'h0000_0108,
  parameter logic [31:0] A_FIFO      = 32'h0000_1000,
  parameter logic [31:0] V_PROBE     = 32'h5EED_0001,
  parameter logic [31:0] V_REPLY     = 32'h5EED_0002,
  parameter logic [31:0] V_PEND      = 32'h0000_FFFF,
  parameter logic [31:0] V_OK        = 32'h0000_0001,
  parameter int          RST_BIT     = 14,
  parameter int          CLKOFF_BIT  = 15,
  parameter int          PROBE_LIM   = 100,
  parameter int          GET_LIM     = 100,
  parameter int          FIN_LIM     = 300
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] img_len,
  input  logic [7:0]  in_data,
  input  logic        in_valid,
  output logic        in_ready,
  output logic        bus_req,
  output logic        bus_we,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic        bus_ack,
  input  logic [31:0] bus_rdata,
  output logic        done,
  output logic        err,
  output logic [2:0]  err_code
);
  localparam int          WPB   = BLK_BYTES / 4;
  localparam int          WW    = (WPB > 1) ? $clog2(WPB) : 1;
  localparam logic [31:0] SLACK = 32'(FIFO_BYTES - BLK_BYTES);
  localparam logic [31:0] FMASK = 32'(FIFO_BYTES - 1);
  localparam logic [31:0] BLK   = 32'(BLK_BYTES);
  localparam logic [31:0] CLR1  = ~(32'd1 << RST_BIT);
  localparam logic [31:0] CLR2  = CLR1 & ~(32'd1 << CLKOFF_BIT);

  typedef enum logic [3:0] {
    S_IDLE, S_INIT, S_NOP, S_CRD, S_CW1, S_CW2, S_PROBE, S_SIZE,
    S_STAT, S_GET, S_FILL, S_WORD, S_PUT, S_FIN, S_WAIT
  } st_t;

  st_t         st, ret;
  logic [15:0] cnt;
  logic [31:0] dly, len, put, cfgv, word;
  logic [WW-1:0] wi;
  logic [1:0]  bc;
  logic        req_q, done_q, err_q;
  logic [2:0]  code_q;

  wire [31:0] gidx   = put + (32'(wi) << 2) + 32'(bc);
  wire        have   = gidx < len;
  wire [31:0] rem    = len - put;
  wire [31:0] put_nx = put + ((rem < BLK) ? rem : BLK);
  wire [31:0] wait_c = 32'(cnt) * 32'(CYC_PER_MS);
  wire [15:0] step_c = cnt + 16'd1 + (cnt >> 1);

  assign in_ready = (st == S_FILL) && have;
  assign bus_req  = req_q;
  assign done     = done_q;
  assign err      = err_q;
  assign err_code = code_q;

  always_comb begin
    bus_we    = 1'b1;
    bus_addr  = '0;
    bus_wdata = '0;
    case (st)
      S_INIT:
        case (cnt[2:0])
          3'd0:    begin bus_addr = A_SIZE;  bus_wdata = V_PROBE; end
          3'd1:    bus_addr = A_PUT;
          3'd2:    bus_addr = A_GET;
          3'd3:    begin bus_addr = A_STAT;  bus_wdata = V_PEND; end
          default: bus_addr = A_FLAGS;
        endcase
      S_NOP: begin
        bus_addr  = cnt[0] ? A_DPORT : A_SRAM_BASE;
        bus_wdata = cnt[0] ? 32'hEAFF_FFFE : 32'hFFF2_0000;
      end
      S_CRD:   begin bus_we = 1'b0; bus_addr = A_CFG; end
      S_CW1:   begin bus_addr = A_CFG; bus_wdata = cfgv & CLR1; end
      S_CW2:   begin bus_addr = A_CFG; bus_wdata = cfgv & CLR2; end
      S_PROBE: begin bus_we = 1'b0; bus_addr = A_SIZE; end
      S_SIZE:  begin bus_addr = A_SIZE; bus_wdata = len; end
      S_STAT, S_FIN: begin bus_we = 1'b0; bus_addr = A_STAT; end
      S_GET:   begin bus_we = 1'b0; bus_addr = A_GET; end
      S_WORD:  begin bus_addr = A_FIFO + (put & FMASK) + (32'(wi) << 2); bus_wdata = word; end
      S_PUT:   begin bus_addr = A_PUT; bus_wdata = put_nx; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ret <= S_IDLE; cnt <= '0; dly <= '0; len <= '0; put <= '0;
      cfgv <= '0; word <= '0; wi <= '0; bc <= '0;
      req_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0; code_q <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (start) begin
            len <= img_len; put <= '0; cnt <= '0;
            done_q <= 1'b0; err_q <= 1'b0; code_q <= '0;
            st <= S_INIT;
          end
        S_WAIT:
          if (dly == 0) st <= ret;
          else dly <= dly - 32'd1;
        S_FILL:
          if (!have || in_valid) begin
            word[{bc, 3'b000} +: 8] <= have ? in_data : 8'h00;
            bc <= bc + 2'd1;
            if (bc == 2'd3) st <= S_WORD;
          end
        default:
          if (!req_q) begin
            if (st == S_PROBE && cnt >= 16'(PROBE_LIM)) begin
              err_q <= 1'b1; code_q <= 3'd1; st <= S_IDLE;
            end else if (st == S_GET && cnt >= 16'(GET_LIM)) begin
              err_q <= 1'b1; code_q <= 3'd3; st <= S_IDLE;
            end else if (st == S_FIN && cnt >= 16'(FIN_LIM)) begin
              err_q <= 1'b1; code_q <= 3'd4; st <= S_IDLE;
            end else begin
              req_q <= 1'b1;
            end
          end else if (bus_ack) begin
            req_q <= 1'b0;
            case (st)
              S_INIT: if (cnt == 16'd4) begin cnt <= '0; st <= S_NOP; end
                      else cnt <= cnt + 16'd1;
              S_NOP:  if (cnt == 16'd1) begin cnt <= '0; st <= S_CRD; end
                      else cnt <= cnt + 16'd1;
              S_CRD:  begin cfgv <= bus_rdata; st <= S_CW1; end
              S_CW1:  st <= S_CW2;
              S_CW2:  st <= S_PROBE;
              S_PROBE:
                if (bus_rdata == V_REPLY) st <= S_SIZE;
                else begin dly <= wait_c; cnt <= step_c; ret <= S_PROBE; st <= S_WAIT; end
              S_SIZE: begin cnt <= '0; st <= (len == 0) ? S_FIN : S_STAT; end
              S_STAT:
                if (bus_rdata != V_PEND) begin err_q <= 1'b1; code_q <= 3'd2; st <= S_IDLE; end
                else begin cnt <= '0; st <= S_GET; end
              S_GET:
                if (put - bus_rdata <= SLACK) begin wi <= '0; bc <= '0; st <= S_FILL; end
                else begin dly <= wait_c; cnt <= cnt + 16'd1; ret <= S_GET; st <= S_WAIT; end
              S_WORD:
                if (wi == WW'(WPB - 1)) st <= S_PUT;
                else begin wi <= wi + 1'b1; st <= S_FILL; end
              S_PUT: begin put <= put_nx; cnt <= '0; st <= (put_nx >= len) ? S_FIN : S_STAT; end
              S_FIN:
                if (bus_rdata == V_PEND) begin
                  dly <= wait_c; cnt <= step_c; ret <= S_FIN; st <= S_WAIT;
                end else if (bus_rdata == V_OK) begin
                  done_q <= 1'b1; st <= S_IDLE;
                end else begin
                  err_q <= 1'b1; code_q <= 3'd4; st <= S_IDLE;
                end
              default: st <= S_IDLE;
            endcase
          end
      endcase
    end
  end

  // R12
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we));
  // R12
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack |=> !bus_req);
  // R13
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(done && err));
  // R13
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) && !start |=> $stable(done) && $stable(err) && $stable(err_code));
  // R11
  ready_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n) in_ready |-> !bus_req);
  // R9
  put_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) put <= len);
endmodule

// File: tb/fw_push_engine_bench.sv
module fw_push_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CPM = 2, BLK = 16, FIFO = 64;
  localparam logic [31:0] A_SIZE = 32'h0, A_PUT = 32'h4, A_GET = 32'h8, A_STAT = 32'hC,
    A_FLAGS = 32'h10, A_SRAM = 32'h100, A_DPORT = 32'h104, A_CFG = 32'h108, A_FIFO = 32'h1000;
  localparam logic [31:0] PROBE = 32'h5EED_0001, REPLY = 32'h5EED_0002,
    PEND = 32'h0000_FFFF, OKV = 32'h0000_0001, CFG_VAL = 32'h0000_C0A5;

  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] img_len = 0;
  logic [7:0] in_data = 0;
  logic in_valid = 0, in_ready, bus_req, bus_we, bus_ack = 0, done, err;
  logic [31:0] bus_addr, bus_wdata, bus_rdata = 0;
  logic [2:0] err_code;

  int checks = 0, errors = 0, consumed = 0, cyc = 0, last_ack = 0;
  bit running = 0;
  logic [64:0] q_tx[$];
  logic [31:0] q_rd[$];
  int q_gap[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fw_push_engine #(.BLK_BYTES(BLK), .FIFO_BYTES(FIFO), .CYC_PER_MS(CPM)) u_fw_push_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .img_len(img_len), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .done(done), .err(err), .err_code(err_code));

  task automatic chk(bit ok, string tag, logic [64:0] act, logic [64:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int k);
    return 8'((k * 37 + 11) & 255);
  endfunction

  task automatic push_w(logic [31:0] a, logic [31:0] d);
    q_tx.push_back({1'b1, a, d}); q_rd.push_back(32'h0); q_gap.push_back(0);
  endtask
  task automatic push_r(logic [31:0] a, logic [31:0] rd, int gap);
    q_tx.push_back({1'b0, a, 32'h0}); q_rd.push_back(rd); q_gap.push_back(gap);
  endtask

  // remote side: pops the expected sequence and answers
  initial forever begin
    @(negedge clk);
    cyc++;
    if (bus_req && !bus_ack) begin
      if (q_tx.size() == 0) begin
        chk(0, "R12 unexpected transaction", {bus_we, bus_addr, bus_wdata}, 65'h0);
        bus_rdata = 0;
      end else begin
        logic [64:0] e;
        int g;
        e = q_tx.pop_front(); bus_rdata = q_rd.pop_front(); g = q_gap.pop_front();
        chk(bus_we == e[64] && bus_addr == e[63:32] && (!e[64] || bus_wdata == e[31:0]),
            "R1-R10 transaction order (R8 R9)", {bus_we, bus_addr, bus_wdata}, e);
        chk(cyc - last_ack >= g, "R4 R7 backoff gap", 65'(cyc - last_ack), 65'(g));
      end
      bus_ack = 1;
      last_ack = cyc;
    end else bus_ack = 0;
    if (running && q_tx.size() > 0 && (done || err))
      chk(0, "R13 early result", {done, err}, 65'h0);
  end

  // image byte source
  initial begin
    bit took = 0;
    int ph = 0;
    forever begin
      @(negedge clk);
      if (took) consumed++;
      in_valid = (ph % 3) != 2;
      in_data = pat(consumed);
      ph++;
      took = in_valid && in_ready;
    end
  end

  task automatic build(int len, int nfail, int gmode, int errblk, int npend, logic [31:0] finv,
                       output int code, output int bytes);
    int i, k, gap, put, b, t, g, stp;
    bit ok;
    logic [31:0] v, wd;
    code = 0; bytes = 0;
    push_w(A_SIZE, PROBE); push_w(A_PUT, 0); push_w(A_GET, 0);
    push_w(A_STAT, PEND); push_w(A_FLAGS, 0);
    push_w(A_SRAM, 32'hFFF2_0000); push_w(A_DPORT, 32'hEAFF_FFFE);
    push_r(A_CFG, CFG_VAL, 0);
    push_w(A_CFG, CFG_VAL & ~(32'd1 << 14));
    push_w(A_CFG, CFG_VAL & ~(32'd1 << 14) & ~(32'd1 << 15));
    i = 0; k = 0; gap = 0; ok = 0;
    while (i < 100) begin
      if (nfail >= 0 && k == nfail) begin push_r(A_SIZE, REPLY, gap); ok = 1; break; end
      push_r(A_SIZE, 32'h0, gap);
      gap = i * CPM; i = i + 1 + i / 2; k++;
    end
    if (!ok) begin code = 1; return; end
    push_w(A_SIZE, len);
    put = 0; b = 0;
    while (put < len) begin
      push_r(A_STAT, (b == errblk) ? 32'h0000_0BAD : PEND, 0);
      if (b == errblk) begin code = 2; return; end
      t = 0; gap = 0; ok = 0;
      while (t < 100) begin
        g = (gmode == 0) ? put : (gmode == 1) ? ((t == 0) ? 0 : put - 16) : 0;
        push_r(A_GET, g, gap);
        if (put - g <= FIFO - BLK) begin ok = 1; break; end
        gap = t * CPM; t++;
      end
      if (!ok) begin code = 3; return; end
      for (int w = 0; w < BLK / 4; w++) begin
        wd = 0;
        for (int j = 0; j < 4; j++)
          if (put + 4 * w + j < len) begin wd[8*j +: 8] = pat(put + 4 * w + j); bytes++; end
        push_w(A_FIFO + 32'((put % FIFO) + 4 * w), wd);
      end
      stp = (len - put < BLK) ? len - put : BLK;
      put += stp;
      push_w(A_PUT, put);
      b++;
    end
    i = 0; k = 0; gap = 0; v = PEND;
    while (i < 300) begin
      v = (k < npend) ? PEND : finv;
      push_r(A_STAT, v, gap);
      if (v != PEND) break;
      gap = i * CPM; i = i + 1 + i / 2; k++;
    end
    code = (v == OKV) ? 0 : 4;
  endtask

  task automatic run(string tag, int len, int nfail, int gmode, int errblk, int npend,
                     logic [31:0] finv);
    int ecode, ebytes, n;
    build(len, nfail, gmode, errblk, npend, finv, ecode, ebytes);
    @(negedge clk);
    consumed = 0; running = 1;
    start = 1; img_len = len;
    @(negedge clk);
    start = 0;
    chk(!done && !err, {tag, " R13 start clears result"}, {done, err}, 65'h0);
    n = 0;
    while (!(done || err) && n < 40000) begin @(negedge clk); n++; end
    if (n >= 40000) chk(0, {tag, " watchdog"}, 65'(n), 65'h0);
    repeat (2) @(negedge clk);
    running = 0;
    chk(err_code == 3'(ecode), {tag, " R4 R6 R7 R10 code"}, 65'(err_code), 65'(ecode));
    chk(done == (ecode == 0) && err == (ecode != 0), {tag, " R13 done/err"},
        {done, err}, {ecode == 0, ecode != 0});
    chk(q_tx.size() == 0, {tag, " R5 all transactions seen"}, 65'(q_tx.size()), 65'h0);
    chk(consumed == ebytes, {tag, " R11 bytes taken"}, 65'(consumed), 65'(ebytes));
    repeat (4) @(negedge clk);
    chk(done == (ecode == 0) && err == (ecode != 0) && !bus_req, {tag, " R13 hold"},
        {done, err}, {ecode == 0, ecode != 0});
    q_tx.delete(); q_rd.delete(); q_gap.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !err && err_code == 0 && !bus_req && !in_ready, "R13 reset state",
        {done, err, err_code, bus_req, in_ready}, 65'h0);
    rst_n = 1;
    run("short-tail", 37, 2, 0, -1, 2, OKV);          // R1 R2 R3 R8 R9 R10
    run("wrap-lag", 80, 0, 1, -1, 0, OKV);            // R7 R8 wrap
    run("no-reply", 20, -1, 0, -1, 0, OKV);           // R4 code 1
    run("bad-status", 40, 1, 0, 1, 0, OKV);           // R6 code 2
    run("stuck-get", 80, 0, 2, -1, 0, OKV);           // R7 code 3
    run("bad-final", 20, 0, 0, -1, 1, 32'h0000_0BAD); // R10 code 4
    run("final-limit", 16, 0, 0, -1, 1000, OKV);      // R10 limit
    run("empty", 0, 0, 0, -1, 0, OKV);                // R5 zero length
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule